// File: doc/BRIEF.md
# Packed Rounding Right-Shift Unit

This block shifts the lanes of 32-bit words to the right, with every lane handled in parallel. It supports three operations.

- Four signed bytes are shifted arithmetically, with optional rounding.
- Two unsigned halfwords are shifted logically.
- A narrowing step shifts two signed 32-bit words arithmetically, with optional rounding, and packs their low halves into one word.

When rounding is on and the shift is not zero, the bit that was shifted out last is added back to the lane. A shift of zero passes the operand through untouched.

An operation enters as a single-cycle strobe carrying:
- one or two 32-bit operands,
- a 5-bit shift amount,
- a 2-bit operation code,
- a round enable.

One clock later the registered result appears with its own strobe. An unused operation code gives a zero result and raises a flag. Results and the flag hold their values between accepted operations. The block does not saturate and has no status flags.

Top module: `pshift_unit`

## Requirements
- R1: While rst_n is low and after its release, out_valid, result and illegal_op are all 0 until an operation is accepted.
- R2: An operation presented with in_valid high is reported one cycle later, with out_valid high for exactly that cycle. Without in_valid, out_valid is low, and result and illegal_op keep their previous values.
- R3: op_sel encodings are 2'b00 byte shift, 2'b01 halfword shift, 2'b10 narrowing and 2'b11 unused. The unused code gives result 0 with illegal_op 1. Every used code gives illegal_op 0.
- R4: The byte shift treats each byte of src_a as a signed value and shifts it arithmetically by shamt[2:0], filling each byte with copies of its own sign. shamt[4:3] has no effect.
- R5: With round_en high and a nonzero effective shift s, a lane gets 1 added when bit s-1 of its original value is 1. The sum keeps only the lane's width, so any carry out of the lane is dropped.
- R6: An effective shift of zero returns each lane unchanged, whatever round_en is.
- R7: The halfword shift moves each 16-bit half of src_a right by shamt[3:0] and fills it with zeros. round_en and shamt[4] have no effect.
- R8: Narrowing shifts src_a and src_b, each as a signed 32-bit word, by shamt[4:0]. Each word is rounded on its own. The low 16 bits of src_a's result form result[31:16], and the low 16 bits of src_b's result form result[15:0].
- R9: src_b has no effect on the byte and halfword shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | Operation code |
| round_en | input | 1 | Rounding enable |
| shamt | input | 5 | Shift amount; each operation uses its own low bits |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand, used only by narrowing |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Registered result |
| illegal_op | output | 1 | Unused operation code was presented |

## Verification
Rounding and the zero-shift bypass are both requested in the same operation whenever round_en is high and the effective shift is zero. The bypass must win, so the operand must come back unchanged.

This case is provoked in three ways:
- Directed operations with round_en set and shamt zero, for each operation.
- Byte shifts where shamt has only its upper bits set, so the effective shift is zero although shamt is not.
- Random stimulus that often leaves the effective shift at zero.

Each result is compared with a reference that applies the bypass before rounding. The checker also asserts the pass-through directly.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SHAMT_W  = 5;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned HALF_W   = 16;
  localparam int unsigned N_BYTES  = WORD_W / BYTE_W;
  localparam int unsigned N_HALVES = WORD_W / HALF_W;
  localparam int unsigned BYTE_SW  = $clog2(BYTE_W);
  localparam int unsigned HALF_SW  = $clog2(HALF_W);
  localparam int unsigned WORD_SW  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    OP_BYTE_SRA = 2'b00,
    OP_HALF_SRL = 2'b01,
    OP_NARROW   = 2'b10,
    OP_RSVD     = 2'b11
  } pshift_op_e;

endpackage

// File: rtl/pshift_lane.sv
// One lane: right shift (arithmetic or logical) of a W-bit value by an
// SW-bit amount, optional round-half-up using the last bit shifted out,
// truncated to OUT_W bits. Requires 2**SW == W.
module pshift_lane #(
  parameter int unsigned W     = 8,
  parameter int unsigned SW    = 3,
  parameter int unsigned OUT_W = 8,
  parameter bit          ARITH = 1'b1
) (
  input  logic [W-1:0]     din,
  input  logic [SW-1:0]    sh,
  input  logic             rnd,
  output logic [OUT_W-1:0] dout
);

  logic [SW-1:0] lost_idx;
  logic          lost_bit;
  logic          inc;

  // Index of the last bit that leaves the lane; only meaningful for sh != 0.
  assign lost_idx = sh - SW'(1);
  assign lost_bit = din[lost_idx];
  assign inc      = rnd && (sh != '0) && lost_bit;

  generate
    if (ARITH) begin : g_arith
      assign dout = OUT_W'($signed(din) >>> sh) + OUT_W'(inc);
    end else begin : g_logic
      assign dout = OUT_W'(din >> sh) + OUT_W'(inc);
    end
  endgenerate

endmodule

// File: rtl/pshift_byte_path.sv
module pshift_byte_path
  import pshift_pkg::*;
#(
  parameter int unsigned LANES = N_BYTES
) (
  input  logic [LANES*BYTE_W-1:0] src,
  input  logic [BYTE_SW-1:0]      sh,
  input  logic                    rnd,
  output logic [LANES*BYTE_W-1:0] dst
);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      pshift_lane #(
        .W     (BYTE_W),
        .SW    (BYTE_SW),
        .OUT_W (BYTE_W),
        .ARITH (1'b1)
      ) u_lane (
        .din  (src[i*BYTE_W +: BYTE_W]),
        .sh   (sh),
        .rnd  (rnd),
        .dout (dst[i*BYTE_W +: BYTE_W])
      );
    end
  endgenerate

endmodule

// File: rtl/pshift_half_path.sv
module pshift_half_path
  import pshift_pkg::*;
#(
  parameter int unsigned LANES = N_HALVES
) (
  input  logic [LANES*HALF_W-1:0] src,
  input  logic [HALF_SW-1:0]      sh,
  output logic [LANES*HALF_W-1:0] dst
);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      pshift_lane #(
        .W     (HALF_W),
        .SW    (HALF_SW),
        .OUT_W (HALF_W),
        .ARITH (1'b0)
      ) u_lane (
        .din  (src[i*HALF_W +: HALF_W]),
        .sh   (sh),
        .rnd  (1'b0),
        .dout (dst[i*HALF_W +: HALF_W])
      );
    end
  endgenerate

endmodule

// File: rtl/pshift_narrow_path.sv
// Two words shifted and rounded independently; the first lands in the upper half.
module pshift_narrow_path
  import pshift_pkg::*;
(
  input  logic [WORD_W-1:0]  hi_src,
  input  logic [WORD_W-1:0]  lo_src,
  input  logic [WORD_SW-1:0] sh,
  input  logic               rnd,
  output logic [WORD_W-1:0]  dst
);

  logic [WORD_W-1:0] srcs [N_HALVES];
  assign srcs[1] = hi_src;
  assign srcs[0] = lo_src;

  generate
    for (genvar i = 0; i < N_HALVES; i++) begin : g_word
      pshift_lane #(
        .W     (WORD_W),
        .SW    (WORD_SW),
        .OUT_W (HALF_W),
        .ARITH (1'b1)
      ) u_lane (
        .din  (srcs[i]),
        .sh   (sh),
        .rnd  (rnd),
        .dout (dst[i*HALF_W +: HALF_W])
      );
    end
  endgenerate

endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
  import pshift_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         op_sel,
  input  logic               round_en,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [WORD_W-1:0]  src_a,
  input  logic [WORD_W-1:0]  src_b,
  output logic               out_valid,
  output logic [WORD_W-1:0]  result,
  output logic               illegal_op
);

  logic [WORD_W-1:0] byte_res;
  logic [WORD_W-1:0] half_res;
  logic [WORD_W-1:0] narrow_res;

  logic [WORD_W-1:0] res_nxt;
  logic              ill_nxt;
  logic [WORD_W-1:0] res_q;
  logic              ill_q;
  logic              vld_q;

  pshift_byte_path u_byte (
    .src (src_a),
    .sh  (shamt[BYTE_SW-1:0]),
    .rnd (round_en),
    .dst (byte_res)
  );

  pshift_half_path u_half (
    .src (src_a),
    .sh  (shamt[HALF_SW-1:0]),
    .dst (half_res)
  );

  pshift_narrow_path u_narrow (
    .hi_src (src_a),
    .lo_src (src_b),
    .sh     (shamt[WORD_SW-1:0]),
    .rnd    (round_en),
    .dst    (narrow_res)
  );

  // Result select
  always_comb begin
    res_nxt = '0;
    ill_nxt = 1'b0;
    unique case (pshift_op_e'(op_sel))
      OP_BYTE_SRA: res_nxt = byte_res;
      OP_HALF_SRL: res_nxt = half_res;
      OP_NARROW:   res_nxt = narrow_res;
      default:     ill_nxt = 1'b1;
    endcase
  end

  // Strobe register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end

  // Data registers, loaded only on an accepted operation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ill_q <= 1'b0;
    end else if (in_valid) begin
      res_q <= res_nxt;
      ill_q <= ill_nxt;
    end
  end

  assign out_valid  = vld_q;
  assign result     = res_q;
  assign illegal_op = ill_q;

endmodule

// File: rtl/pshift_unit_chk.sv
module pshift_unit_chk
  import pshift_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         op_sel,
  input logic [SHAMT_W-1:0] shamt,
  input logic [WORD_W-1:0]  src_a,
  input logic [WORD_W-1:0]  src_b,
  input logic               out_valid,
  input logic [WORD_W-1:0]  result,
  input logic               illegal_op
);

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(illegal_op)));

  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11) |=> (illegal_op && result == '0));

  p_legal_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel != 2'b11) |=> !illegal_op);

  p_byte_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b00 && shamt[2:0] == 3'd0) |=> result == $past(src_a));

  p_half_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b01 && shamt[3:0] == 4'd0) |=> result == $past(src_a));

  p_narrow_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b10 && shamt == '0)
      |=> result == {$past(src_a[15:0]), $past(src_b[15:0])});

  p_half_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b01 && shamt[3:0] != 4'd0)
      |=> (!result[31] && !result[15]));

endmodule

bind pshift_unit pshift_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .op_sel     (op_sel),
  .shamt      (shamt),
  .src_a      (src_a),
  .src_b      (src_b),
  .out_valid  (out_valid),
  .result     (result),
  .illegal_op (illegal_op)
);

// File: tb/pshift_unit_bench.sv
module pshift_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op_sel;
  logic        round_en;
  logic [4:0]  shamt;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic        out_valid;
  logic [31:0] result;
  logic        illegal_op;

  int checks = 0;
  int fails  = 0;
  logic [31:0] last_res;
  logic        last_ill;

  pshift_unit u_pshift_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .round_en   (round_en),
    .shamt      (shamt),
    .src_a      (src_a),
    .src_b      (src_b),
    .out_valid  (out_valid),
    .result     (result),
    .illegal_op (illegal_op)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements: {illegal, result}
  function automatic logic [32:0] ref_model(input logic [1:0] op, input logic rnd,
                                            input logic [4:0] sh, input logic [31:0] a,
                                            input logic [31:0] b);
    logic [31:0] r;
    logic signed [7:0]  q;
    logic [7:0]  qr;
    logic [15:0] h;
    logic signed [31:0] w;
    logic [31:0] wr;
    logic [31:0] src;
    int s;
    r = '0;
    case (op)
      2'b00: begin
        s = int'(sh[2:0]);
        for (int i = 0; i < 4; i++) begin
          q = a[8*i +: 8];
          if (s == 0) qr = q;
          else begin
            qr = q >>> s;
            if (rnd && q[s-1]) qr = qr + 8'd1;
          end
          r[8*i +: 8] = qr;
        end
        return {1'b0, r};
      end
      2'b01: begin
        s = int'(sh[3:0]);
        for (int i = 0; i < 2; i++) begin
          h = a[16*i +: 16];
          r[16*i +: 16] = h >> s;
        end
        return {1'b0, r};
      end
      2'b10: begin
        s = int'(sh);
        for (int i = 0; i < 2; i++) begin
          src = (i == 1) ? a : b;
          w = src;
          if (s == 0) wr = w;
          else begin
            wr = w >>> s;
            if (rnd && w[s-1]) wr = wr + 32'd1;
          end
          r[16*i +: 16] = wr[15:0];
        end
        return {1'b0, r};
      end
      default: return {1'b1, 32'h0};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] op, input logic rnd, input logic [4:0] sh);
    if (op == 2'b11) return "R3";
    if (op == 2'b00 && sh[2:0] == 0) return "R6";
    if (op == 2'b01 && sh[3:0] == 0) return "R6";
    if (op == 2'b10) return "R8";
    if (op == 2'b01) return "R7";
    if (rnd) return "R5";
    return "R4";
  endfunction

  // Drive one operation at a falling edge, check at the next falling edge
  task automatic run_op(input logic [1:0] op, input logic rnd, input logic [4:0] sh,
                        input logic [31:0] a, input logic [31:0] b);
    logic [32:0] e;
    string tag;
    e = ref_model(op, rnd, sh, a, b);
    tag = req_of(op, rnd, sh);
    in_valid = 1'b1; op_sel = op; round_en = rnd; shamt = sh; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", {31'b0, out_valid}, 32'd1);
    check(tag, result, e[31:0]);
    check("R3", {31'b0, illegal_op}, {31'b0, e[32]});
    last_res = e[31:0];
    last_ill = e[32];
  endtask

  task automatic idle_check();
    src_a = $urandom; src_b = $urandom; op_sel = 2'($urandom); shamt = 5'($urandom);
    @(negedge clk);
    check("R2", {31'b0, out_valid}, 32'd0);
    check("R2", result, last_res);
    check("R2", {31'b0, illegal_op}, {31'b0, last_ill});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rb;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 2'b00; round_en = 1'b0;
    shamt = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    check("R1", {31'b0, out_valid}, 32'd0);
    check("R1", result, 32'd0);
    check("R1", {31'b0, illegal_op}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {31'b0, out_valid}, 32'd0);
    check("R1", result, 32'd0);
    last_res = '0; last_ill = 1'b0;

    // R4: sign fill per byte, upper shamt bits ignored
    run_op(2'b00, 1'b0, 5'd3, 32'h80_7F_F0_01, 32'hDEAD_BEEF);
    run_op(2'b00, 1'b0, 5'b11_111, 32'h81_40_FF_7E, 32'h0);
    // R5: rounding per byte, including lanes at extremes
    run_op(2'b00, 1'b1, 5'd1, 32'h80_7F_01_FF, 32'h0);
    run_op(2'b00, 1'b1, 5'd7, 32'h7F_C0_40_80, 32'h0);
    // R6: zero effective shift with rounding requested
    run_op(2'b00, 1'b1, 5'b11_000, 32'hFF_81_7F_55, 32'h0);
    run_op(2'b01, 1'b1, 5'b1_0000, 32'hFFFF_8001, 32'h1234_5678);
    run_op(2'b10, 1'b1, 5'd0, 32'h89AB_CDEF, 32'h0123_4567);
    // R7: zero fill, rounding ignored
    run_op(2'b01, 1'b1, 5'd15, 32'hFFFF_8000, 32'h0);
    run_op(2'b01, 1'b1, 5'd1, 32'h0003_FFFF, 32'h0);
    // R8: independent narrowing of two words
    run_op(2'b10, 1'b1, 5'd31, 32'h8000_0000, 32'h4000_0000);
    run_op(2'b10, 1'b1, 5'd16, 32'h7FFF_8000, 32'hFFFF_7FFF);
    run_op(2'b10, 1'b0, 5'd4, 32'h1234_5678, 32'hF000_000F);
    // R3: unused code, then a legal op clears the flag
    run_op(2'b11, 1'b1, 5'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    idle_check();
    run_op(2'b00, 1'b0, 5'd2, 32'h1234_5678, 32'h0);
    // R9: src_b changes without effect on byte and halfword ops
    rb = 32'h0;
    run_op(2'b01, 1'b0, 5'd5, 32'hABCD_1234, rb);
    run_op(2'b01, 1'b0, 5'd5, 32'hABCD_1234, ~rb);
    run_op(2'b00, 1'b1, 5'd2, 32'h9A3F_66C7, ~rb);

    // Random mix, back-to-back and with idle gaps
    for (int n = 0; n < 600; n++) begin
      run_op(2'($urandom), 1'($urandom), 5'($urandom), $urandom, $urandom);
      if (($urandom % 4) == 0) idle_check();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule